// File: doc/BRIEF.md
# Dual-Lane Link Frame Classifier

This block watches a 64-bit internal data path between a link layer and a physical layer. The path carries two 32-bit lanes per clock. The upper lane (`beat_data[63:32]`) holds the earlier DWORD of the beat and the lower lane (`beat_data[31:0]`) holds the later one. Each lane has a frame line and an active-low control line. A change of level on a lane's frame line, in either direction, opens a new frame in that lane. The control line tells transaction-layer content apart from link-layer packets and idle fill.

Every frame is sorted from its opening DWORD. The classes are transaction packet (TLP), link packet (DLLP), idle fill, or unclassifiable. A frame lasts until the next frame opens in either lane, so a packet may open in the later lane of one beat and close in the earlier lane of a later beat. When a TLP or DLLP frame closes, the block issues one event. The event carries the packet class, the lane the packet opened in, a 12-bit tag (the sequence number of a TLP or the type byte of a DLLP) and the length in DWORDs. Saturating totals count TLPs, DLLPs and unclassifiable frames. CRC checking and header decoding are left to other logic.

Top module: `link_frame_sorter`

## Requirements
- R1: A frame-line level that differs from the same lane's level on the previous clock opens a frame in that lane. Within one beat the upper lane is treated as slot 0 (earlier) and the lower lane as slot 1 (later). A frame covers every slot from its opening slot up to the slot before the next opening in any lane.
- R2: An opening DWORD is classified by these rules. With control low, it is a TLP when bits [31:24] are 0x00. With control high, it is idle fill when it equals 0xFF000000 or 0x000000FF, and otherwise a DLLP when bits [31:24] are 0x00. Any other opening DWORD is unclassifiable. `evt_is_dllp` is 1 for a DLLP event and 0 for a TLP event.
- R3: `evt_valid` pulses for one clock on the clock edge after the beat that holds the opening which closes a TLP or DLLP frame. Idle and unclassifiable frames never produce an event.
- R4: `evt_tag` holds bits [19:8] of the opening DWORD for a TLP, which are the low 12 bits of the two bytes after the pad. For a DLLP it holds bits [23:16] of that DWORD, zero-extended to 12 bits.
- R5: `evt_late_slot` is 0 when the packet opened in the upper lane and 1 when it opened in the lower lane.
- R6: `evt_dwords` is the number of DWORD slots the frame covered. It saturates at 2^LEN_W-1.
- R7: A TLP or DLLP frame that covers fewer than 2 DWORDs is unclassifiable and gives no event. As a result, at most one event is issued per beat.
- R8: `tlp_total` and `dllp_total` each rise by one in the same clock as the matching event. Each saturates at 2^CNT_W-1 and holds when no matching event is issued.
- R9: `bad_total` adds one for every unclassifiable opening and for every TLP or DLLP frame that closes too short. It updates on the clock edge after the beat and saturates at 2^CNT_W-1.
- R10: While `rst_n` is low, all outputs are zero and both remembered frame levels are zero. The first high frame level after reset therefore opens a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one beat per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_data | input | 64 | Two DWORD lanes; [63:32] is the earlier slot |
| frame_tgl | input | 2 | Frame lines; bit 1 upper lane, bit 0 lower lane |
| tlp_ctl_n | input | 2 | Active-low TLP content marker per lane; bit 1 upper |
| evt_valid | output | 1 | One-cycle packet completion event |
| evt_is_dllp | output | 1 | Event class: 1 DLLP, 0 TLP |
| evt_late_slot | output | 1 | Opening lane: 0 upper, 1 lower |
| evt_tag | output | 12 | Sequence number or zero-extended DLLP type |
| evt_dwords | output | LEN_W | Packet length in DWORDs, saturating |
| tlp_total | output | CNT_W | Saturating TLP count |
| dllp_total | output | CNT_W | Saturating DLLP count |
| bad_total | output | CNT_W | Saturating unclassifiable-frame count |

## Verification
The frame state carried across beats holds the open frame's class, opening lane, tag and running length. A fault in that state first shows on the next event, which can be many beats later. The bench therefore runs a reference model on every clock and compares event fields and all three totals on every cycle, so a divergence is reported at the first port where it becomes visible. A wrong lane history shows up one clock later as a missing or spurious opening, which changes `evt_valid` or `bad_total` at once. Streams that open packets in the lower lane and close them in the upper lane of a later beat exercise the carried state. Saturation of lengths and counts is driven to its limit.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  localparam int DW_BITS = 32;
  localparam int SLOTS   = 2;
  localparam int TAG_W   = 12;

  typedef enum logic [2:0] {
    FK_NONE, FK_TLP, FK_DLLP, FK_IDLE, FK_BAD
  } frame_kind_e;

  // Class of a frame from its opening DWORD and control line.
  function automatic frame_kind_e kind_of(logic [DW_BITS-1:0] dw, logic ctl_n);
    if (!ctl_n) return (dw[31:24] == 8'h00) ? FK_TLP : FK_BAD;
    if (dw == 32'hFF00_0000 || dw == 32'h0000_00FF) return FK_IDLE;
    if (dw[31:24] == 8'h00) return FK_DLLP;
    return FK_BAD;
  endfunction

  // Event tag: sequence number for TLP, type byte for DLLP.
  function automatic logic [TAG_W-1:0] tag_of(logic [DW_BITS-1:0] dw, frame_kind_e k);
    return (k == FK_DLLP) ? {4'h0, dw[23:16]} : dw[19:8];
  endfunction
endpackage

// File: rtl/lfs_toggle_det.sv
module lfs_toggle_det #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] level,
  output logic [LANES-1:0] flip
);
  logic [LANES-1:0] last_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) last_q[g] <= 1'b0;
      else        last_q[g] <= level[g];
    end
    assign flip[g] = level[g] ^ last_q[g];
  end
endmodule

// File: rtl/lfs_slot_class.sv
module lfs_slot_class
  import lfs_pkg::*;
(
  input  logic [DW_BITS-1:0] dw,
  input  logic               ctl_n,
  output frame_kind_e        kind,
  output logic [TAG_W-1:0]   tag
);
  always_comb begin
    kind = kind_of(dw, ctl_n);
    tag  = tag_of(dw, kind);
  end
endmodule

// File: rtl/lfs_frame_walk.sv
module lfs_frame_walk
  import lfs_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOTS-1:0]    slot_start,
  input  frame_kind_e         slot_kind [SLOTS],
  input  logic [TAG_W-1:0]    slot_tag  [SLOTS],
  output logic                evt_valid,
  output logic                evt_is_dllp,
  output logic                evt_late_slot,
  output logic [TAG_W-1:0]    evt_tag,
  output logic [LEN_W-1:0]    evt_dwords,
  output logic                close_tlp,
  output logic                close_dllp,
  output logic [2:0]          bad_hits
);
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  function automatic logic [LEN_W-1:0] len_step(logic [LEN_W-1:0] n);
    return (n == LEN_MAX) ? n : n + 1'b1;
  endfunction

  frame_kind_e        cur_kind_q, nxt_kind;
  logic               cur_slot_q, nxt_slot;
  logic [TAG_W-1:0]   cur_tag_q,  nxt_tag;
  logic [LEN_W-1:0]   cur_len_q,  nxt_len;
  logic               fire, f_dllp, f_slot;
  logic [TAG_W-1:0]   f_tag;
  logic [LEN_W-1:0]   f_len;

  // Walk the slots of this beat in time order.
  always_comb begin
    nxt_kind = cur_kind_q;
    nxt_slot = cur_slot_q;
    nxt_tag  = cur_tag_q;
    nxt_len  = cur_len_q;
    fire = 1'b0; f_dllp = 1'b0; f_slot = 1'b0;
    f_tag = '0;  f_len = '0;    bad_hits = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slot_start[i]) begin
        if (nxt_kind == FK_TLP || nxt_kind == FK_DLLP) begin
          if (nxt_len >= LEN_W'(2)) begin
            fire   = 1'b1;
            f_dllp = (nxt_kind == FK_DLLP);
            f_slot = nxt_slot;
            f_tag  = nxt_tag;
            f_len  = nxt_len;
          end else begin
            bad_hits = bad_hits + 3'd1;
          end
        end
        nxt_kind = slot_kind[i];
        nxt_slot = 1'(i);
        nxt_tag  = slot_tag[i];
        nxt_len  = LEN_W'(1);
        if (slot_kind[i] == FK_BAD) bad_hits = bad_hits + 3'd1;
      end else if (nxt_kind != FK_NONE) begin
        nxt_len = len_step(nxt_len);
      end
    end
  end

  assign close_tlp  = fire && !f_dllp;
  assign close_dllp = fire &&  f_dllp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_kind_q    <= FK_NONE;
      cur_slot_q    <= 1'b0;
      cur_tag_q     <= '0;
      cur_len_q     <= '0;
      evt_valid     <= 1'b0;
      evt_is_dllp   <= 1'b0;
      evt_late_slot <= 1'b0;
      evt_tag       <= '0;
      evt_dwords    <= '0;
    end else begin
      cur_kind_q <= nxt_kind;
      cur_slot_q <= nxt_slot;
      cur_tag_q  <= nxt_tag;
      cur_len_q  <= nxt_len;
      evt_valid  <= fire;
      if (fire) begin
        evt_is_dllp   <= f_dllp;
        evt_late_slot <= f_slot;
        evt_tag       <= f_tag;
        evt_dwords    <= f_len;
      end
    end
  end
endmodule

// File: rtl/lfs_tally.sv
module lfs_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_tlp,
  input  logic             add_dllp,
  input  logic [2:0]       add_bad,
  output logic [CNT_W-1:0] tlp_total,
  output logic [CNT_W-1:0] dllp_total,
  output logic [CNT_W-1:0] bad_total
);
  localparam logic [CNT_W:0] CAP = {1'b0, {CNT_W{1'b1}}};

  function automatic logic [CNT_W-1:0] sat_add(logic [CNT_W-1:0] c, logic [2:0] a);
    logic [CNT_W:0] s;
    s = {1'b0, c} + (CNT_W+1)'(a);
    return (s > CAP) ? CAP[CNT_W-1:0] : s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tlp_total  <= '0;
      dllp_total <= '0;
      bad_total  <= '0;
    end else begin
      tlp_total  <= sat_add(tlp_total,  {2'b00, add_tlp});
      dllp_total <= sat_add(dllp_total, {2'b00, add_dllp});
      bad_total  <= sat_add(bad_total,  add_bad);
    end
  end
endmodule

// File: rtl/link_frame_sorter.sv
module link_frame_sorter
  import lfs_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SLOTS*DW_BITS-1:0] beat_data,
  input  logic [SLOTS-1:0]      frame_tgl,
  input  logic [SLOTS-1:0]      tlp_ctl_n,
  output logic                  evt_valid,
  output logic                  evt_is_dllp,
  output logic                  evt_late_slot,
  output logic [TAG_W-1:0]      evt_tag,
  output logic [LEN_W-1:0]      evt_dwords,
  output logic [CNT_W-1:0]      tlp_total,
  output logic [CNT_W-1:0]      dllp_total,
  output logic [CNT_W-1:0]      bad_total
);
  logic [SLOTS-1:0] lane_flip;
  logic [SLOTS-1:0] slot_start;
  frame_kind_e      slot_kind [SLOTS];
  logic [TAG_W-1:0] slot_tag  [SLOTS];
  logic             close_tlp, close_dllp;
  logic [2:0]       bad_hits;

  lfs_toggle_det #(.LANES(SLOTS)) i_tgl (
    .clk(clk), .rst_n(rst_n), .level(frame_tgl), .flip(lane_flip)
  );

  // Slot 0 is the upper lane (earlier in time), slot 1 the lower lane.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int LANE = SLOTS - 1 - s;
    assign slot_start[s] = lane_flip[LANE];
    lfs_slot_class i_cls (
      .dw   (beat_data[LANE*DW_BITS +: DW_BITS]),
      .ctl_n(tlp_ctl_n[LANE]),
      .kind (slot_kind[s]),
      .tag  (slot_tag[s])
    );
  end

  lfs_frame_walk #(.LEN_W(LEN_W)) i_walk (
    .clk(clk), .rst_n(rst_n),
    .slot_start(slot_start), .slot_kind(slot_kind), .slot_tag(slot_tag),
    .evt_valid(evt_valid), .evt_is_dllp(evt_is_dllp),
    .evt_late_slot(evt_late_slot), .evt_tag(evt_tag), .evt_dwords(evt_dwords),
    .close_tlp(close_tlp), .close_dllp(close_dllp), .bad_hits(bad_hits)
  );

  lfs_tally #(.CNT_W(CNT_W)) i_tally (
    .clk(clk), .rst_n(rst_n),
    .add_tlp(close_tlp), .add_dllp(close_dllp), .add_bad(bad_hits),
    .tlp_total(tlp_total), .dllp_total(dllp_total), .bad_total(bad_total)
  );
endmodule

// File: rtl/lfs_checker.sv
module lfs_checker #(
  parameter int LEN_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       slot_start,
  input logic             evt_valid,
  input logic             evt_is_dllp,
  input logic [11:0]      evt_tag,
  input logic [LEN_W-1:0] evt_dwords,
  input logic [CNT_W-1:0] tlp_total,
  input logic [CNT_W-1:0] dllp_total,
  input logic [CNT_W-1:0] bad_total
);
  assert_event_after_opening_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(|slot_start));

  assert_no_short_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> evt_dwords >= LEN_W'(2));

  assert_dllp_tag_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_is_dllp) |-> evt_tag[11:8] == 4'h0);

  assert_tlp_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_is_dllp) |-> (tlp_total == CNT_W'($past(tlp_total) + 1'b1) || &tlp_total));

  assert_tlp_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_valid && !evt_is_dllp) |-> $stable(tlp_total));

  assert_dllp_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_is_dllp) |-> (dllp_total == CNT_W'($past(dllp_total) + 1'b1) || &dllp_total));

  assert_dllp_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_valid && evt_is_dllp) |-> $stable(dllp_total));

  assert_bad_never_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_total >= $past(bad_total));
endmodule

bind link_frame_sorter lfs_checker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_lfs_checker (
  .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
  .evt_valid(evt_valid), .evt_is_dllp(evt_is_dllp), .evt_tag(evt_tag),
  .evt_dwords(evt_dwords), .tlp_total(tlp_total), .dllp_total(dllp_total),
  .bad_total(bad_total)
);

// File: tb/test_link_frame_sorter.sv
`timescale 1ns/1ps
module test_link_frame_sorter;
  localparam int LW = 5;
  localparam int CW = 4;
  localparam int LMAX = (1 << LW) - 1;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [63:0]   beat_data = '0;
  logic [1:0]    frame_tgl = '0;
  logic [1:0]    tlp_ctl_n = 2'b11;
  logic          evt_valid, evt_is_dllp, evt_late_slot;
  logic [11:0]   evt_tag;
  logic [LW-1:0] evt_dwords;
  logic [CW-1:0] tlp_total, dllp_total, bad_total;

  always #2.5 clk = ~clk;

  link_frame_sorter #(.LEN_W(LW), .CNT_W(CW)) i_link_frame_sorter (
    .clk(clk), .rst_n(rst_n), .beat_data(beat_data), .frame_tgl(frame_tgl),
    .tlp_ctl_n(tlp_ctl_n), .evt_valid(evt_valid), .evt_is_dllp(evt_is_dllp),
    .evt_late_slot(evt_late_slot), .evt_tag(evt_tag), .evt_dwords(evt_dwords),
    .tlp_total(tlp_total), .dllp_total(dllp_total), .bad_total(bad_total)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic check(string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", what, got, exp, $time);
    end
  endtask

  // Reference model: open frame 0 none, 1 tlp, 2 dllp, 3 idle, 4 bad
  int m_kind = 0, m_slot = 0, m_tag = 0, m_len = 0;
  bit m_prev [2] = '{0, 0};
  int x_valid = 0, x_dllp = 0, x_slot = 0, x_tag = 0, x_len = 0;
  int x_tlpc = 0, x_dllpc = 0, x_badc = 0;

  function automatic int bump(int v, int cap);
    return (v >= cap) ? cap : v + 1;
  endfunction

  function automatic void model_beat(logic [63:0] d, logic [1:0] tg, logic [1:0] cn);
    x_valid = 0;
    for (int i = 0; i < 2; i++) begin
      int lane;
      logic [31:0] w;
      bit opened;
      lane = 1 - i;
      w = (lane == 1) ? d[63:32] : d[31:0];
      opened = (tg[lane] != m_prev[lane]);
      m_prev[lane] = tg[lane];
      if (opened) begin
        if (m_kind == 1 || m_kind == 2) begin
          if (m_len >= 2) begin
            x_valid = 1; x_dllp = (m_kind == 2) ? 1 : 0;
            x_slot = m_slot; x_tag = m_tag; x_len = m_len;
            if (m_kind == 1) x_tlpc = bump(x_tlpc, CMAX);
            else             x_dllpc = bump(x_dllpc, CMAX);
          end else x_badc = bump(x_badc, CMAX);
        end
        if (cn[lane] == 1'b0) m_kind = (w[31:24] == 0) ? 1 : 4;
        else if (w == 32'hFF000000 || w == 32'h000000FF) m_kind = 3;
        else m_kind = (w[31:24] == 0) ? 2 : 4;
        if (m_kind == 4) x_badc = bump(x_badc, CMAX);
        m_tag = (m_kind == 2) ? int'(w[23:16]) : int'(w[19:8]);
        m_slot = i; m_len = 1;
      end else if (m_kind != 0) begin
        m_len = (m_len >= LMAX) ? LMAX : m_len + 1;
      end
    end
  endfunction

  typedef struct { logic [31:0] d; bit st; bit cn; } slot_t;
  slot_t sq[$];
  bit lvl_hi = 0, lvl_lo = 0;

  task automatic push(logic [31:0] d, bit st, bit cn);
    slot_t s; s.d = d; s.st = st; s.cn = cn; sq.push_back(s);
  endtask
  task automatic add_tlp(int seq, int ndw);
    push({8'h00, 4'hA, seq[11:0], 8'h5C}, 1, 0);
    for (int k = 1; k < ndw; k++) push(32'hC0DE0000 + k, 0, 0);
  endtask
  task automatic add_dllp(logic [7:0] typ);
    push({8'h00, typ, 16'h1234}, 1, 1);
    push(32'h00ABCDEF, 0, 1);
  endtask
  task automatic add_idle(logic [31:0] pat, int ndw);
    push(pat, 1, 1);
    for (int k = 1; k < ndw; k++) push(pat, 0, 1);
  endtask

  task automatic beat(logic [63:0] d, logic [1:0] tg, logic [1:0] cn);
    @(negedge clk);
    beat_data = d; frame_tgl = tg; tlp_ctl_n = cn;
    model_beat(d, tg, cn);
    @(posedge clk); #1;
    check("R1 R3 R7 evt_valid", evt_valid, x_valid);
    if (x_valid) begin
      check("R2 evt_is_dllp", evt_is_dllp, x_dllp);
      check("R5 evt_late_slot", evt_late_slot, x_slot);
      check("R4 evt_tag", evt_tag, x_tag);
      check("R6 evt_dwords", evt_dwords, x_len);
    end
    check("R8 tlp_total", tlp_total, x_tlpc);
    check("R8 dllp_total", dllp_total, x_dllpc);
    check("R9 bad_total", bad_total, x_badc);
  endtask

  task automatic drain();
    if (sq.size() % 2) push(32'hFF000000, 0, 1);
    while (sq.size() >= 2) begin
      slot_t a, b;
      a = sq.pop_front(); b = sq.pop_front();
      if (a.st) lvl_hi = ~lvl_hi;
      if (b.st) lvl_lo = ~lvl_lo;
      beat({a.d, b.d}, {lvl_hi, lvl_lo}, {a.cn, b.cn});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 1 expected 0 (run did not end)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: outputs zero during reset
    check("R10 evt_valid in reset", evt_valid, 0);
    check("R10 tlp_total in reset", tlp_total, 0);
    check("R10 bad_total in reset", bad_total, 0);
    @(negedge clk); rst_n = 1'b1;
    // R10: idle opens at first high level after reset
    add_idle(32'hFF000000, 2);
    // R1/R4/R5: TLP opening in upper lane
    add_tlp(12'h123, 4); add_idle(32'hFF000000, 2);
    // R2: ACK DLLP opening in lower lane
    add_idle(32'hFF000000, 1); add_dllp(8'h00); add_idle(32'h000000FF, 1);
    // UpdateFC non-posted DLLP, then TLP from lower lane into later upper lane
    add_dllp(8'h90); add_idle(32'hFF000000, 1);
    add_tlp(12'hABC, 3); add_tlp(12'h7FF, 5); add_idle(32'hFF000000, 3);
    // R2: unclassifiable with control high and control low
    push(32'h5A5A5A5A, 1, 1); push(32'h5A5A5A5B, 0, 1);
    push(32'h7F000000, 1, 0); push(32'h11111111, 0, 0);
    add_idle(32'hFF000000, 2);
    // R7: one-DWORD TLP and DLLP frames
    add_tlp(12'h001, 1); add_dllp(8'h00); push(32'h00C00000, 1, 1); add_idle(32'hFF000000, 1);
    // R6: length saturation
    add_tlp(12'h456, 40); add_idle(32'hFF000000, 2);
    drain();
    // R8/R9: counter saturation
    for (int k = 0; k < 18; k++) begin add_dllp(8'h90); add_tlp(k, 3); end
    for (int k = 0; k < 18; k++) begin push(32'h12345678, 1, 1); push(32'h0, 0, 1); end
    add_idle(32'hFF000000, 2);
    drain();
    repeat (2) beat({32'hFF000000, 32'hFF000000}, {lvl_hi, lvl_lo}, 2'b11);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule